// File: doc/BRIEF.md
# Multiplexed Segment LCD Scan Controller

This block scans a multiplexed segment LCD with 40 frontplane pins and up to four backplane pins. A prescaler divides the system clock by a selectable power of two to make the LCD clock. Each LCD clock tick moves the scan to the next backplane phase. The frame has as many phases as the selected duty has backplanes. In each phase the backplane being scanned drives its select level and the other used backplanes drive a non-select level. Each enabled frontplane drives an on level or an off level, chosen by the segment bit for that frontplane in the current backplane's row.

The outputs are 2-bit drive-level codes, one per pin, plus an output enable per pin. They select among four bias voltages (1/3 bias) that are generated outside the block. The drive polarity inverts at the end of every frame, so each segment sees zero average DC. Software-side state is loaded through simple write strobes: the scan configuration (duty and divider), the display enable, the frontplane enables, and one segment row at a time. Duty and divider changes wait for the next frame boundary. Clearing the display enable floats every pin and parks the scan.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: After reset every output enable is 0 and every level code is 0. Enabling the display without a configuration write scans 4 backplanes with divider code 0.
- R2: A frontplane output enable is 1 only when both the display enable and that pin's enable bit are 1. A pin whose output enable is 0 shows level code 0. With the display disabled, all frontplane and backplane enables are 0.
- R3: The scan moves to the next phase every 2^(BASE_DIV_LOG2+c) clocks, where c is the 3-bit divider code. Codes 6 and 7 act as code 5.
- R4: Duty code d (2 bits) gives a frame of d+1 phases. The phases run from backplane 0 up to backplane d and then wrap to 0.
- R5: Backplanes with an index above d have output enable 0. With the display enabled, exactly one backplane drives the select level.
- R6: Level codes are 0=V0, 1=V1, 2=V2 and 3=V3. With polarity 0: backplane select=3, non-select=1, frontplane on=0, frontplane off=2. With polarity 1: select=0, non-select=2, on=3, off=1.
- R7: Polarity starts at 0 when the display is enabled and toggles at every frame boundary.
- R8: A duty or divider write made mid-frame takes effect at the next frame boundary, and the scan then restarts at backplane 0.
- R9: Segment row b, bit i sets frontplane i to on (1) or off (0) while backplane b is scanned. A row write shows at the outputs on the next clock.
- R10: Clearing the display enable and setting it again restarts the scan at phase 0 with polarity 0, using the latest configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (source of the LCD clock) |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write strobe for duty and divider |
| cfg_duty_i | input | 2 | Duty code (backplanes minus one) |
| cfg_div_i | input | 3 | Divider code |
| en_we_i | input | 1 | Write strobe for display enable |
| en_i | input | 1 | Display enable value |
| fpen_we_i | input | 1 | Write strobe for frontplane enables |
| fpen_i | input | 40 | Frontplane enable bits |
| seg_we_i | input | 1 | Write strobe for one segment row |
| seg_row_i | input | 2 | Backplane row index to write |
| seg_data_i | input | 40 | Segment bits for that row |
| fp_lvl_o | output | 80 | 2-bit level code per frontplane |
| fp_oe_o | output | 40 | Frontplane output enables |
| bp_lvl_o | output | 8 | 2-bit level code per backplane |
| bp_oe_o | output | 4 | Backplane output enables |

## Verification
A faulty phase counter or a faulty prescaler count shows up at the backplane pins within one LCD clock period: the select level lands on the wrong pin or moves at the wrong clock. A polarity bit that is stuck or toggles at the wrong time inverts every code at the next frame boundary. The bench samples each phase at its first and last cycle, so a shift of even one clock is caught. A configuration that is applied too early changes the backplane enables or the phase length inside the frame where it was written, and the directed mid-frame case checks exactly that frame.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int NUM_FP = 40;
  localparam int NUM_BP = 4;
  localparam int DIV_W  = 3;

  typedef enum logic [1:0] {
    LVL_V0 = 2'd0,
    LVL_V1 = 2'd1,
    LVL_V2 = 2'd2,
    LVL_V3 = 2'd3
  } lvl_e;

  function automatic lvl_e bp_code(input logic sel, input logic pol);
    if (pol) return sel ? LVL_V0 : LVL_V2;
    else     return sel ? LVL_V3 : LVL_V1;
  endfunction

  function automatic lvl_e fp_code(input logic on, input logic pol);
    if (pol) return on ? LVL_V3 : LVL_V1;
    else     return on ? LVL_V0 : LVL_V2;
  endfunction
endpackage

// File: rtl/lcd_prescaler.sv
module lcd_prescaler #(
  parameter int DIV_W         = 3,
  parameter int BASE_DIV_LOG2 = 10,
  parameter int MAX_DIV_CODE  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_code_i,
  output logic             tick_o
);
  localparam int CNT_W = BASE_DIV_LOG2 + MAX_DIV_CODE;
  localparam logic [CNT_W:0] ONE = 1;

  logic [CNT_W-1:0] cnt_q;
  logic [DIV_W-1:0] code_c;
  logic [CNT_W:0]   lim_w;
  logic [CNT_W-1:0] lim;

  always_comb begin
    code_c = (div_code_i > DIV_W'(MAX_DIV_CODE)) ? DIV_W'(MAX_DIV_CODE) : div_code_i;
    lim_w  = (ONE << (BASE_DIV_LOG2 + int'(code_c))) - ONE;
    lim    = lim_w[CNT_W-1:0];
  end

  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R3: divider of at least 2 never yields back-to-back ticks
  p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= lim);
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq #(
  parameter int NUM_BP = 4,
  parameter int DIV_W  = 3,
  localparam int BP_W  = $clog2(NUM_BP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [BP_W-1:0]  pend_duty_i,
  input  logic [DIV_W-1:0] pend_div_i,
  output logic [BP_W-1:0]  phase_o,
  output logic             pol_o,
  output logic [BP_W-1:0]  act_duty_o,
  output logic [DIV_W-1:0] act_div_o
);
  logic frame_end;
  assign frame_end = tick_i && (phase_o == act_duty_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o    <= '0;
      pol_o      <= 1'b0;
      act_duty_o <= BP_W'(NUM_BP - 1);
      act_div_o  <= '0;
    end else if (!run_i) begin
      phase_o    <= '0;
      pol_o      <= 1'b0;
      act_duty_o <= pend_duty_i;
      act_div_o  <= pend_div_i;
    end else if (frame_end) begin
      phase_o    <= '0;
      pol_o      <= ~pol_o;
      act_duty_o <= pend_duty_i;
      act_div_o  <= pend_div_i;
    end else if (tick_i) begin
      phase_o    <= phase_o + 1'b1;
    end
  end

  p_phase_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o <= act_duty_o);
  p_pol_at_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && (pol_o != $past(pol_o))) |-> (phase_o == '0));
  p_cfg_at_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && ((act_duty_o != $past(act_duty_o)) ||
     (act_div_o != $past(act_div_o)))) |-> (phase_o == '0));
endmodule

// File: rtl/lcd_level_enc.sv
module lcd_level_enc
  import lcd_scan_pkg::*;
#(
  parameter int NUM_FP = 40,
  parameter int NUM_BP = 4,
  localparam int BP_W  = $clog2(NUM_BP)
) (
  input  logic                disp_en_i,
  input  logic [BP_W-1:0]     phase_i,
  input  logic                pol_i,
  input  logic [BP_W-1:0]     duty_i,
  input  logic [NUM_FP-1:0]   fp_en_i,
  input  logic [NUM_FP-1:0]   seg_row_i,
  output logic [2*NUM_FP-1:0] fp_lvl_o,
  output logic [NUM_FP-1:0]   fp_oe_o,
  output logic [2*NUM_BP-1:0] bp_lvl_o,
  output logic [NUM_BP-1:0]   bp_oe_o
);
  for (genvar g = 0; g < NUM_FP; g++) begin : g_fp
    lvl_e lvl;
    assign lvl                = fp_code(seg_row_i[g], pol_i);
    assign fp_oe_o[g]         = disp_en_i && fp_en_i[g];
    assign fp_lvl_o[2*g +: 2] = fp_oe_o[g] ? lvl : LVL_V0;
  end

  for (genvar b = 0; b < NUM_BP; b++) begin : g_bp
    lvl_e lvl;
    assign lvl                = bp_code(phase_i == BP_W'(b), pol_i);
    assign bp_oe_o[b]         = disp_en_i && (BP_W'(b) <= duty_i);
    assign bp_lvl_o[2*b +: 2] = bp_oe_o[b] ? lvl : LVL_V0;
  end
endmodule

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int NUM_FP        = lcd_scan_pkg::NUM_FP,
  parameter int NUM_BP        = lcd_scan_pkg::NUM_BP,
  parameter int DIV_W         = lcd_scan_pkg::DIV_W,
  parameter int BASE_DIV_LOG2 = 10,
  parameter int MAX_DIV_CODE  = 5,
  localparam int BP_W         = $clog2(NUM_BP)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [BP_W-1:0]     cfg_duty_i,
  input  logic [DIV_W-1:0]    cfg_div_i,
  input  logic                en_we_i,
  input  logic                en_i,
  input  logic                fpen_we_i,
  input  logic [NUM_FP-1:0]   fpen_i,
  input  logic                seg_we_i,
  input  logic [BP_W-1:0]     seg_row_i,
  input  logic [NUM_FP-1:0]   seg_data_i,
  output logic [2*NUM_FP-1:0] fp_lvl_o,
  output logic [NUM_FP-1:0]   fp_oe_o,
  output logic [2*NUM_BP-1:0] bp_lvl_o,
  output logic [NUM_BP-1:0]   bp_oe_o
);
  logic              disp_en_q;
  logic [NUM_FP-1:0] fp_en_q;
  logic [BP_W-1:0]   pend_duty_q;
  logic [DIV_W-1:0]  pend_div_q;
  logic [NUM_FP-1:0] seg_q [NUM_BP];

  logic              tick;
  logic [BP_W-1:0]   phase;
  logic              pol;
  logic [BP_W-1:0]   act_duty;
  logic [DIV_W-1:0]  act_div;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_en_q   <= 1'b0;
      fp_en_q     <= '0;
      pend_duty_q <= BP_W'(NUM_BP - 1);
      pend_div_q  <= '0;
    end else begin
      if (en_we_i)   disp_en_q <= en_i;
      if (fpen_we_i) fp_en_q   <= fpen_i;
      if (cfg_we_i) begin
        pend_duty_q <= cfg_duty_i;
        pend_div_q  <= cfg_div_i;
      end
    end
  end

  for (genvar r = 0; r < NUM_BP; r++) begin : g_seg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  seg_q[r] <= '0;
      else if (seg_we_i && (seg_row_i == BP_W'(r))) seg_q[r] <= seg_data_i;
    end
  end

  lcd_prescaler #(
    .DIV_W        (DIV_W),
    .BASE_DIV_LOG2(BASE_DIV_LOG2),
    .MAX_DIV_CODE (MAX_DIV_CODE)
  ) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (disp_en_q),
    .div_code_i(act_div),
    .tick_o    (tick)
  );

  lcd_phase_seq #(
    .NUM_BP(NUM_BP),
    .DIV_W (DIV_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (disp_en_q),
    .tick_i     (tick),
    .pend_duty_i(pend_duty_q),
    .pend_div_i (pend_div_q),
    .phase_o    (phase),
    .pol_o      (pol),
    .act_duty_o (act_duty),
    .act_div_o  (act_div)
  );

  lcd_level_enc #(
    .NUM_FP(NUM_FP),
    .NUM_BP(NUM_BP)
  ) u_enc (
    .disp_en_i(disp_en_q),
    .phase_i  (phase),
    .pol_i    (pol),
    .duty_i   (act_duty),
    .fp_en_i  (fp_en_q),
    .seg_row_i(seg_q[phase]),
    .fp_lvl_o (fp_lvl_o),
    .fp_oe_o  (fp_oe_o),
    .bp_lvl_o (bp_lvl_o),
    .bp_oe_o  (bp_oe_o)
  );

  logic [NUM_BP-1:0] sel_seen;
  always_comb begin
    for (int b = 0; b < NUM_BP; b++)
      sel_seen[b] = bp_oe_o[b] && (bp_lvl_o[2*b +: 2] == (pol ? LVL_V0 : LVL_V3));
  end

  p_hiz_when_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_en_q |-> ((fp_oe_o == '0) && (bp_oe_o == '0)));
  p_one_select_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_en_q |-> ($countones(sel_seen) == 1));
endmodule

// File: tb/tb_lcd_scan_ctrl.sv
module tb_lcd_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NFP = 40;
  localparam int NBP = 4;
  localparam int BASE = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_duty = '0;
  logic [2:0]       cfg_div = '0;
  logic             en_we = 1'b0;
  logic             en = 1'b0;
  logic             fpen_we = 1'b0;
  logic [NFP-1:0]   fpen = '0;
  logic             seg_we = 1'b0;
  logic [1:0]       seg_row = '0;
  logic [NFP-1:0]   seg_data = '0;
  logic [2*NFP-1:0] fp_lvl;
  logic [NFP-1:0]   fp_oe;
  logic [2*NBP-1:0] bp_lvl;
  logic [NBP-1:0]   bp_oe;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  logic [NFP-1:0] m_ram [NBP];
  logic [NFP-1:0] m_fpen = '0;
  logic           m_en = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_scan_ctrl #(.BASE_DIV_LOG2(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_duty_i(cfg_duty), .cfg_div_i(cfg_div),
    .en_we_i(en_we), .en_i(en),
    .fpen_we_i(fpen_we), .fpen_i(fpen),
    .seg_we_i(seg_we), .seg_row_i(seg_row), .seg_data_i(seg_data),
    .fp_lvl_o(fp_lvl), .fp_oe_o(fp_oe), .bp_lvl_o(bp_lvl), .bp_oe_o(bp_oe)
  );

  function automatic int div_of(input int code);
    return 1 << (BASE + ((code > 5) ? 5 : code));
  endfunction

  function automatic logic [1:0] bp_exp(input logic sel, input logic pol);
    if (pol) return sel ? 2'd0 : 2'd2;
    return sel ? 2'd3 : 2'd1;
  endfunction

  function automatic logic [1:0] fp_exp(input logic on, input logic pol);
    if (pol) return on ? 2'd3 : 2'd1;
    return on ? 2'd0 : 2'd2;
  endfunction

  task automatic cmp(input int ph, input logic pol, input int nbp, input string tag);
    logic [2*NFP-1:0] e_fl;
    logic [NFP-1:0]   e_fo;
    logic [2*NBP-1:0] e_bl;
    logic [NBP-1:0]   e_bo;
    for (int b = 0; b < NBP; b++) begin
      e_bo[b] = m_en && (b < nbp);
      e_bl[2*b +: 2] = e_bo[b] ? bp_exp(b == ph, pol) : 2'd0;
    end
    for (int i = 0; i < NFP; i++) begin
      e_fo[i] = m_en && m_fpen[i];
      e_fl[2*i +: 2] = e_fo[i] ? fp_exp(m_ram[ph][i], pol) : 2'd0;
    end
    checks++;
    if (bp_oe !== e_bo || bp_lvl !== e_bl) begin
      fails++;
      $display("FAIL %s k=%0d bp_oe=%h exp %h bp_lvl=%h exp %h", tag, k, bp_oe, e_bo, bp_lvl, e_bl);
    end
    checks++;
    if (fp_oe !== e_fo || fp_lvl !== e_fl) begin
      fails++;
      $display("FAIL %s k=%0d fp_oe=%h exp %h fp_lvl=%h exp %h", tag, k, fp_oe, e_fo, fp_lvl, e_fl);
    end
  endtask

  task automatic adv_to(input int kk);
    while (k < kk) begin
      @(negedge clk);
      k++;
    end
  endtask

  // check the free-running state kk cycles after enable
  task automatic check_at(input int kk, input int nbp, input int dv, input string tag);
    adv_to(kk);
    cmp((kk / dv) % nbp, logic'(((kk / dv) / nbp) % 2), nbp, tag);
  endtask

  task automatic pulse();
    @(posedge clk);
    #1;
    cfg_we = 0; en_we = 0; fpen_we = 0; seg_we = 0;
    @(negedge clk);
    k++;
  endtask

  task automatic wr_cfg(input int d, input int c);
    cfg_we = 1; cfg_duty = 2'(d); cfg_div = 3'(c);
    pulse();
  endtask

  task automatic wr_en(input logic v);
    en_we = 1; en = v; m_en = v;
    pulse();
    if (v) k = 0;
  endtask

  task automatic wr_fpen(input logic [NFP-1:0] v);
    fpen_we = 1; fpen = v; m_fpen = v;
    pulse();
  endtask

  task automatic wr_seg(input int r, input logic [NFP-1:0] v);
    seg_we = 1; seg_row = 2'(r); seg_data = v; m_ram[r] = v;
    pulse();
  endtask

  function automatic logic [NFP-1:0] rnd40();
    return {$urandom, $urandom};
  endfunction

  task automatic scan_frames(input int nbp, input int dv, input string tag);
    for (int j = 0; j < 2 * nbp; j++) begin
      check_at(j * dv, nbp, dv, tag);
      check_at(j * dv + dv - 1, nbp, dv, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c0d_5eed));
    for (int r = 0; r < NBP; r++) m_ram[r] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state, everything floating
    cmp(0, 1'b0, 4, "R1 reset");
    rst_n = 1;
    @(negedge clk);
    cmp(0, 1'b0, 4, "R1 after reset");

    for (int r = 0; r < NBP; r++) wr_seg(r, rnd40());
    wr_fpen(rnd40());
    cmp(0, 1'b0, 4, "R2 display off");
    // R1 default: 4 backplanes, divider code 0; R3 R4 R6 R7 R9 scan
    wr_en(1'b1);
    scan_frames(4, div_of(0), "R1 R3 R4 R6 R7 R9 default");

    // R2: enable bits update while scanning
    wr_fpen(rnd40());
    cmp(((k) / div_of(0)) % 4, logic'(((k / div_of(0)) / 4) % 2), 4, "R2 fpen");
    // R9: row rewrite while scanning is seen next clock
    wr_seg(((k) / div_of(0)) % 4, rnd40());
    cmp(((k) / div_of(0)) % 4, logic'(((k / div_of(0)) / 4) % 2), 4, "R9 live row");

    // random configurations; R10 restart each time
    for (int t = 0; t < 8; t++) begin
      int d, c;
      d = $urandom_range(0, 3);
      c = (t == 0) ? 5 : (t == 1) ? 7 : $urandom_range(0, 7);
      wr_en(1'b0);
      cmp(0, 1'b0, 4, "R2 off");
      wr_cfg(d, c);
      for (int r = 0; r < NBP; r++) wr_seg(r, rnd40());
      if (t == 2) wr_fpen('1); else wr_fpen(rnd40());
      wr_en(1'b1);
      scan_frames(d + 1, div_of(c), "R3 R4 R5 R7 R10 random");
    end

    // all segments on, then all off: R6 levels per polarity
    wr_en(1'b0);
    wr_cfg(3, 0);
    for (int r = 0; r < NBP; r++) wr_seg(r, '1);
    wr_fpen('1);
    wr_en(1'b1);
    check_at(2, 4, 4, "R6 on pol0");
    check_at(18, 4, 4, "R6 on pol1");
    wr_en(1'b0);
    for (int r = 0; r < NBP; r++) wr_seg(r, '0);
    wr_en(1'b1);
    check_at(2, 4, 4, "R6 off pol0");
    check_at(18, 4, 4, "R6 off pol1");

    // R8: mid-frame change held to frame boundary
    wr_en(1'b0);
    for (int r = 0; r < NBP; r++) wr_seg(r, rnd40());
    wr_cfg(3, 0);
    wr_en(1'b1);
    adv_to(5);
    wr_cfg(1, 1);
    cmp(1, 1'b0, 4, "R8 old cfg k=6");
    adv_to(15);
    cmp(3, 1'b0, 4, "R8 old cfg last");
    adv_to(16);
    cmp(0, 1'b1, 2, "R8 new cfg boundary");
    adv_to(23);
    cmp(0, 1'b1, 2, "R8 new div");
    adv_to(24);
    cmp(1, 1'b1, 2, "R8 new phase1");
    adv_to(32);
    cmp(0, 1'b0, 2, "R8 wrap pol");

    // R10: disable mid-frame and re-enable keeps latest cfg
    wr_en(1'b0);
    cmp(0, 1'b0, 2, "R10 off");
    wr_en(1'b1);
    check_at(0, 2, 8, "R10 restart");
    check_at(8, 2, 8, "R10 phase1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule